// File: doc/BRIEF.md
# Linked-List Sharing Chain Coherence Manager

This block keeps track of which caches hold a copy of each memory block. Instead of a bit per cache, the home table holds one head pointer per block. The sharers are threaded into a doubly linked chain through per-cache forward and backward pointer tags, which are modelled here as register arrays. A pointer value of 0 means null. A non-null pointer names cache node n with the value n+1.

A read request adds the requester at the front of the chain. It touches only the home entry and the current first sharer, and it finishes one cycle after it is accepted. A write request walks the chain from the head. It spends one cycle on each member and raises an invalidation for every member except the writer, because the next sharer only becomes known once the current one has been visited. When the walk reaches the null terminator, the block pulses done and leaves the writer as the only member of the chain. Requests are accepted one at a time through a valid/ready handshake.

Top module: `sharing_chain`

## Requirements
- R1: After reset every home head pointer and every cache pointer tag is null, so the first write to any block produces no invalidation and completes on the first cycle after acceptance.
- R2: `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, `req_ready` is low on the following cycle, and it returns high on the cycle after `done`.
- R3: A read by a node that is not in the block's chain raises `done` on the first cycle after acceptance. On that cycle `done_link` carries the previous head pointer (node n encoded as n+1, 0 when the chain was empty). The requester becomes the new head, and the old head's backward pointer now points to it.
- R4: A read by a node that is already in the chain leaves the chain unchanged. `done` comes one cycle after acceptance, and `done_link` carries that node's forward pointer (0 when it is the tail).
- R5: A write walks the chain from head to tail, one member per cycle. It pulses `inv_valid` with `inv_node` set to the member's node index for every member except the writer. On the writer's own visit cycle there is no pulse.
- R6: A write to a chain of k members, with the writer counted when present, raises `done` exactly k+1 cycles after acceptance.
- R7: After a write completes, the writer is the sole member of the chain. A later write by another node invalidates only the writer, and a later read by another node receives the writer as its `done_link`.
- R8: Chains of different blocks are independent. A request for one block never changes the chain of another block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write (invalidate walk), 0 = read (head insert) |
| req_block | input | $clog2(BLOCKS) | Memory block index |
| req_node | input | $clog2(NODES) | Requesting cache node index |
| done | output | 1 | One-cycle completion pulse |
| done_link | output | $clog2(NODES+1) | Read result: next sharer pointer (0 = null) |
| inv_valid | output | 1 | Invalidation issued this cycle |
| inv_node | output | $clog2(NODES) | Node being invalidated |

## Verification
The assertions assume that requests are presented only through the handshake, and that `req_node` and `req_block` lie within `NODES` and `BLOCKS`. Under those conditions the chains keep their linked-list shape, and the latched writer identity is meaningful whenever an invalidation or a done pulse appears. The bench keeps within these assumptions. It drives only in-range indices, raises `req_valid` only while `req_ready` is high, and drops it right after acceptance. A long pseudo-random sequence of reads and writes over four nodes and four blocks is checked against a list model kept in the bench, which predicts link values, invalidation order and walk length.

// File: rtl/sharing_chain.sv
`timescale 1ns/1ps
module sharing_chain #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 4,
  localparam int NW = $clog2(NODES),
  localparam int BW = $clog2(BLOCKS),
  localparam int PW = $clog2(NODES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [BW-1:0] req_block,
  input  logic [NW-1:0] req_node,
  output logic          done,
  output logic [PW-1:0] done_link,
  output logic          inv_valid,
  output logic [NW-1:0] inv_node
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WALK} state_t;

  state_t        st;
  logic [BW-1:0] op_blk;
  logic [NW-1:0] op_node;
  logic [PW-1:0] cur;
  logic [PW-1:0] head [BLOCKS];
  logic [PW-1:0] fwd  [NODES][BLOCKS];
  logic [PW-1:0] bwd  [NODES][BLOCKS];

  logic [PW-1:0] self_ptr, old_head;
  logic [NW-1:0] cur_idx, old_idx;
  logic          member, walk_end;

  assign self_ptr  = PW'(op_node) + 1'b1;
  assign old_head  = head[op_blk];
  assign old_idx   = NW'(old_head - 1'b1);
  assign cur_idx   = NW'(cur - 1'b1);
  assign member    = (old_head == self_ptr) || (bwd[op_node][op_blk] != '0);
  assign walk_end  = (st == S_WALK) && (cur == '0);

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_RD) || walk_end;
  assign done_link = (st != S_RD) ? '0 : (member ? fwd[op_node][op_blk] : old_head);
  assign inv_valid = (st == S_WALK) && (cur != '0) && (cur != self_ptr);
  assign inv_node  = cur_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_blk  <= '0;
      op_node <= '0;
      cur     <= '0;
      for (int b = 0; b < BLOCKS; b++) begin
        head[b] <= '0;
        for (int n = 0; n < NODES; n++) begin
          fwd[n][b] <= '0;
          bwd[n][b] <= '0;
        end
      end
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_blk  <= req_block;
          op_node <= req_node;
          cur     <= head[req_block];
          st      <= req_write ? S_WALK : S_RD;
        end
        S_RD: begin
          if (!member) begin
            fwd[op_node][op_blk] <= old_head;
            bwd[op_node][op_blk] <= '0;
            if (old_head != '0) bwd[old_idx][op_blk] <= self_ptr;
            head[op_blk] <= self_ptr;
          end
          st <= S_IDLE;
        end
        S_WALK: begin
          if (cur != '0) begin
            fwd[cur_idx][op_blk] <= '0;
            bwd[cur_idx][op_blk] <= '0;
            cur <= fwd[cur_idx][op_blk];
          end else begin
            head[op_blk]         <= self_ptr;
            fwd[op_node][op_blk] <= '0;
            bwd[op_node][op_blk] <= '0;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sharing_chain_chk.sv
`timescale 1ns/1ps
module sharing_chain_chk #(
  parameter int NW = 2,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [NW-1:0] req_node,
  input logic          done,
  input logic [PW-1:0] done_link,
  input logic          inv_valid,
  input logic [NW-1:0] inv_node
);
  logic          wr_q;
  logic [NW-1:0] node_q;
  logic          take;

  assign take = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      node_q <= '0;
    end else if (take) begin
      wr_q   <= req_write;
      node_q <= req_node;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) take |=> !req_ready); // R2
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) done |=> req_ready); // R2
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (take && !req_write) |=> done); // R3
  AST_NO_SELF_LINK: assert property (@(posedge clk) disable iff (!rst_n) (done && !wr_q) |-> (done_link != PW'(node_q) + 1'b1)); // R4
  AST_WRITER_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n) inv_valid |-> (wr_q && inv_node != node_q)); // R5
  AST_INV_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n) inv_valid |-> (!done && !req_ready)); // R6
endmodule

bind sharing_chain sharing_chain_chk #(.NW(NW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_node(req_node), .done(done), .done_link(done_link),
  .inv_valid(inv_valid), .inv_node(inv_node)
);

// File: tb/sharing_chain_bench.sv
`timescale 1ns/1ps
module sharing_chain_bench;
  localparam int NODES = 4;
  localparam int BLOCKS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [1:0] req_block = '0;
  logic [1:0] req_node = '0;
  logic req_ready, done, inv_valid;
  logic [2:0] done_link;
  logic [1:0] inv_node;

  sharing_chain #(.NODES(NODES), .BLOCKS(BLOCKS)) u_sharing_chain (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_block(req_block), .req_node(req_node),
    .done(done), .done_link(done_link), .inv_valid(inv_valid), .inv_node(inv_node)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string ctx = "";
  int lst [BLOCKS][NODES];
  int len [BLOCKS];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s%s actual=%0d expected=%0d", req, ctx, act, exp);
    end
  endtask

  task automatic do_op(bit w, int b, int n);
    int pos, ne, got, cyc, exp;
    int exp_inv [NODES];
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_write = w; req_block = 2'(b); req_node = 2'(n);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
    if (!w) begin
      pos = -1;
      for (int i = 0; i < len[b]; i++) if (lst[b][i] == n) pos = i;
      if (pos < 0) begin
        exp = (len[b] > 0) ? lst[b][0] + 1 : 0;
        chk(done == 1'b1, "R3 done", int'(done), 1);
        chk(int'(done_link) == exp, "R3 link", int'(done_link), exp);
        for (int i = len[b]; i > 0; i--) lst[b][i] = lst[b][i-1];
        lst[b][0] = n;
        len[b]++;
      end else begin
        exp = (pos + 1 < len[b]) ? lst[b][pos+1] + 1 : 0;
        chk(done == 1'b1, "R4 done", int'(done), 1);
        chk(int'(done_link) == exp, "R4 link", int'(done_link), exp);
      end
    end else begin
      ne = 0;
      for (int i = 0; i < len[b]; i++) if (lst[b][i] != n) begin exp_inv[ne] = lst[b][i]; ne++; end
      got = 0;
      cyc = 1;
      while (!done && cyc < 20) begin
        if (inv_valid) begin
          if (got < ne) chk(int'(inv_node) == exp_inv[got], "R5 order", int'(inv_node), exp_inv[got]);
          else chk(1'b0, "R5 extra", int'(inv_node), -1);
          got++;
        end
        cyc++;
        @(negedge clk);
      end
      chk(got == ne, "R5 count", got, ne);
      chk(cyc == len[b] + 1, "R6 latency", cyc, len[b] + 1);
      lst[b][0] = n;
      len[b] = 1;
    end
  endtask

  initial begin
    #750000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int b = 0; b < BLOCKS; b++) len[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(inv_valid == 1'b0, "R1 inv", int'(inv_valid), 0);
    ctx = " (R1)";
    for (int b = 0; b < BLOCKS; b++) do_op(1'b1, b, b);
    ctx = " (R8)";
    do_op(1'b0, 0, 1); do_op(1'b0, 0, 2); do_op(1'b0, 0, 3);
    do_op(1'b1, 1, 2);
    do_op(1'b0, 0, 1);
    do_op(1'b1, 0, 0);
    ctx = " (R7)";
    do_op(1'b0, 2, 0); do_op(1'b0, 2, 1); do_op(1'b0, 2, 3);
    do_op(1'b1, 2, 1);
    do_op(1'b0, 2, 3);
    do_op(1'b1, 2, 0);
    do_op(1'b1, 2, 0);
    ctx = "";
    lf = 16'hACE1;
    for (int k = 0; k < 1500; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_op(lf[3:0] < 4'd4, int'(lf[5:4]), int'(lf[7:6]));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule